// File: doc/BRIEF.md
# DMA Channel Launch and Interrupt Control

This block is the register-facing control side of a seven-channel DMA controller. Each channel has three 32-bit registers: a memory address, a block count and a control word. Writing a channel's control word with its go bit set launches that channel, but only if the channel's enable bit in a shared enable register is also set. The launch shows up as a one-cycle pulse on that channel's bit of `chan_go`. The transfer engines sit outside the block. When an engine finishes, it returns a one-cycle pulse on `xfer_done`.

A shared interrupt register gathers the completion flags. It holds per-channel flag enables, a master enable and a forced bus-error bit. It also holds a sticky "already signalled" bit, which limits `irq_out` to a single pulse for each interrupt episode. Software acknowledges a flag by writing one to it. Every write to the interrupt register re-evaluates the sticky bit, so once the condition is gone a later episode can pulse again.

Register reads are combinational from `bus_addr`. Writes take effect at the clock edge that samples `bus_wr`.

Top module: `dma_launch_irq`

## Requirements
- R1: Channel n (0..6) has an address register at byte offset 0x80+0x10*n and a block-count register at 0x84+0x10*n. Both store all 32 written bits and read back unchanged.
- R2: A write to a channel's control register (0x88+0x10*n) stores the written value. If written bit 24 is 1 and bit 3+4*n of the enable register (0xF0) is 1, `chan_go[n]` is high for exactly the one cycle after the write edge.
- R3: A control write with bit 24 set produces no `chan_go` pulse when the channel's enable bit 3+4*n is 0.
- R4: Channel 5's control register (0xD8) ignores writes and always reads 0. It never produces a `chan_go` pulse, whatever the enable register holds.
- R5: A write to the interrupt register (0xF4) stores the written value only in bits 5:0, bit 15 and bits 23:16. Bits 14:6 always read 0.
- R6: Interrupt flag bits 30:24 are cleared where the written bit is 1 and keep their value where it is 0.
- R7: A `xfer_done[n]` pulse sets flag bit 24+n only when enable bit 16+n of the interrupt register is 1. A flag bit rises only on a completion pulse.
- R8: A `xfer_done[n]` pulse clears bit 24 of channel n's control register and leaves its other bits unchanged.
- R9: The interrupt condition is bit 15 set, or bit 23 set together with any flag in bits 30:24. When an update leaves the condition true, bit 31 becomes 1. `irq_out` pulses for one cycle only if bit 31 was 0 before that update.
- R10: Each write to the interrupt register sets bit 31 to the value of the condition after the write, so bit 31 clears when the condition no longer holds.
- R11: After reset, every register reads 0 and `chan_go` and `irq_out` are low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| xfer_done | input | 7 | Per-channel completion pulses from the transfer engines |
| chan_go | output | 7 | Per-channel one-cycle launch pulses |
| irq_out | output | 1 | One-cycle pulse to interrupt-controller source 3 |

## Verification
The assertions assume that `xfer_done` bits are single-cycle pulses and that the bus issues at most one write per cycle. Under that assumption, `chan_go` can be at most one-hot and `irq_out` can never be high on two cycles in a row. The stimulus raises a completion pulse for exactly one cycle, and only in a cycle with no register write. This keeps the flag-source check and the bit-24 clearing free of write/completion collisions.

// File: rtl/dma_launch_irq.sv
module dma_launch_irq #(
  parameter int NUM_CH  = 7,
  parameter int SKIP_CH = 5,
  parameter int AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] chan_go,
  output logic              irq_out
);
  localparam logic [AW-1:0] CH_BASE  = AW'(8'h80);
  localparam logic [AW-1:0] ENA_ADDR = AW'(8'hF0);
  localparam logic [AW-1:0] IRQ_ADDR = AW'(8'hF4);
  localparam logic [31:0]   IRQ_KEEP = 32'h00FF803F;
  localparam logic [31:0]   FLAG_MSK = 32'h7F000000;
  localparam int            GO_BIT   = 24;

  logic [31:0] addr_q [NUM_CH];
  logic [31:0] cnt_q  [NUM_CH];
  logic [31:0] ctl_q  [NUM_CH];
  logic [31:0] ena_q, irq_q;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [AW-1:0] A0 = CH_BASE + AW'(16 * ch);
    wire hit_a = bus_wr && (bus_addr == A0);
    wire hit_n = bus_wr && (bus_addr == A0 + AW'(4));
    wire hit_c = bus_wr && (bus_addr == A0 + AW'(8));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[ch] <= '0;
        cnt_q[ch]  <= '0;
      end else begin
        if (hit_a) addr_q[ch] <= bus_wdata;
        if (hit_n) cnt_q[ch]  <= bus_wdata;
      end
    end

    if (ch == SKIP_CH) begin : g_idle
      assign ctl_q[ch]   = '0;
      assign chan_go[ch] = 1'b0;
    end else begin : g_live
      logic [31:0] ctl_r;
      logic        go_r;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ctl_r <= '0;
          go_r  <= 1'b0;
        end else begin
          if (hit_c) ctl_r <= bus_wdata;
          else if (xfer_done[ch]) ctl_r[GO_BIT] <= 1'b0;
          go_r <= hit_c && bus_wdata[GO_BIT] && ena_q[3 + 4 * ch];
        end
      end
      assign ctl_q[ch]   = ctl_r;
      assign chan_go[ch] = go_r;
    end
  end

  wire         irq_wr = bus_wr && (bus_addr == IRQ_ADDR);
  logic [31:0] irq_base, irq_nx;
  logic [6:0]  flags_nx;
  logic        cond;

  assign irq_base = irq_wr ? ((bus_wdata & IRQ_KEEP) | (irq_q & ~bus_wdata & FLAG_MSK)) : irq_q;
  assign flags_nx = irq_base[30:24] | 7'(xfer_done & irq_base[16 +: NUM_CH]);
  assign cond     = irq_base[15] | (irq_base[23] & (|flags_nx));
  assign irq_nx   = {irq_wr ? cond : (irq_q[31] | cond), flags_nx, irq_base[23:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q   <= '0;
      irq_q   <= '0;
      irq_out <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ENA_ADDR) ena_q <= bus_wdata;
      irq_q   <= irq_nx;
      irq_out <= cond & ~irq_q[31];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ENA_ADDR) bus_rdata = ena_q;
    if (bus_addr == IRQ_ADDR) bus_rdata = irq_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == CH_BASE + AW'(16 * i))     bus_rdata = addr_q[i];
      if (bus_addr == CH_BASE + AW'(16 * i + 4)) bus_rdata = cnt_q[i];
      if (bus_addr == CH_BASE + AW'(16 * i + 8)) bus_rdata = ctl_q[i];
    end
  end
endmodule

// File: rtl/dma_launch_irq_chk.sv
module dma_launch_irq_chk #(
  parameter int NUM_CH = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] xfer_done,
  input logic [NUM_CH-1:0] chan_go,
  input logic              irq_out,
  input logic [31:0]       irq_q
);
  assert_go_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_go));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |=> !irq_out);

  assert_irq_sent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> irq_q[31]);

  assert_flag_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq_q[30:24] & ~$past(irq_q[30:24]))) |-> $past(|xfer_done));
endmodule

bind dma_launch_irq dma_launch_irq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .xfer_done (xfer_done),
  .chan_go   (chan_go),
  .irq_out   (irq_out),
  .irq_q     (irq_q)
);

// File: tb/dma_launch_irq_bench.sv
`timescale 1ns/1ps
module dma_launch_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  xfer_done = '0;
  logic [6:0]  chan_go;
  logic        irq_out;
  int          errs = 0;
  int          total = 0;

  always #2 clk = ~clk;

  dma_launch_irq u_dma_launch_irq (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
    .chan_go(chan_go), .irq_out(irq_out)
  );

  // {wr, addr, wdata, done, read addr, expected read, expected irq, expected go}
  localparam int NV = 18;
  localparam logic [95:0] VEC [0:NV-1] = '{
    {1'b1, 8'h80, 32'h00012340, 7'h00, 8'h80, 32'h00012340, 1'b0, 7'h00}, // R1
    {1'b1, 8'hE4, 32'h0000BEEF, 7'h00, 8'hE4, 32'h0000BEEF, 1'b0, 7'h00}, // R1
    {1'b1, 8'h88, 32'h01000201, 7'h00, 8'h88, 32'h01000201, 1'b0, 7'h00}, // R3
    {1'b1, 8'hF0, 32'h08800008, 7'h00, 8'hF0, 32'h08800008, 1'b0, 7'h00}, // R2 enable
    {1'b1, 8'h88, 32'h01000000, 7'h00, 8'h88, 32'h01000000, 1'b0, 7'h01}, // R2
    {1'b0, 8'h00, 32'h00000000, 7'h01, 8'h88, 32'h00000000, 1'b0, 7'h00}, // R8
    {1'b1, 8'hE8, 32'h01000002, 7'h00, 8'hE8, 32'h01000002, 1'b0, 7'h40}, // R2
    {1'b1, 8'hD8, 32'h01000000, 7'h00, 8'hD8, 32'h00000000, 1'b0, 7'h00}, // R4
    {1'b1, 8'hF4, 32'hFFFFFFFF, 7'h00, 8'hF4, 32'h80FF803F, 1'b1, 7'h00}, // R5
    {1'b1, 8'hF4, 32'h00010000, 7'h00, 8'hF4, 32'h00010000, 1'b0, 7'h00}, // R10
    {1'b1, 8'hF4, 32'h00810000, 7'h00, 8'hF4, 32'h00810000, 1'b0, 7'h00}, // R9
    {1'b0, 8'h00, 32'h00000000, 7'h01, 8'hF4, 32'h81810000, 1'b1, 7'h00}, // R7
    {1'b0, 8'h00, 32'h00000000, 7'h01, 8'hF4, 32'h81810000, 1'b0, 7'h00}, // R9
    {1'b0, 8'h00, 32'h00000000, 7'h02, 8'hF4, 32'h81810000, 1'b0, 7'h00}, // R7
    {1'b1, 8'hF4, 32'h00810000, 7'h00, 8'hF4, 32'h81810000, 1'b0, 7'h00}, // R6
    {1'b1, 8'hF4, 32'h01810000, 7'h00, 8'hF4, 32'h00810000, 1'b0, 7'h00}, // R6
    {1'b0, 8'h00, 32'h00000000, 7'h01, 8'hF4, 32'h81810000, 1'b1, 7'h00}, // R9
    {1'b0, 8'h00, 32'h00000000, 7'h00, 8'hFC, 32'h00000000, 1'b0, 7'h00}  // R11
  };
  string TAG [0:NV-1] = '{"R1", "R1", "R3", "R2", "R2", "R8", "R2", "R4", "R5",
                          "R10", "R9", "R7", "R9", "R7", "R6", "R10", "R9", "R11"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [6:0] dn);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; xfer_done = dn;
    @(negedge clk);
    bus_wr = 1'b0; xfer_done = '0;
  endtask

  task automatic look(input string req, input logic [7:0] a, input logic [31:0] exp,
                      input logic exp_irq, input logic [6:0] exp_go);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    chk(req, 32'(irq_out), 32'(exp_irq));
    chk(req, 32'(chan_go), 32'(exp_go));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    look("R11", 8'hF4, 32'h0, 1'b0, 7'h00);
    look("R11", 8'hF0, 32'h0, 1'b0, 7'h00);
    look("R11", 8'h88, 32'h0, 1'b0, 7'h00);

    for (int i = 0; i < NV; i++) begin
      logic [95:0] v;
      v = VEC[i];
      apply(v[95], v[94:87], v[86:55], v[54:48]);
      look(TAG[i], v[47:40], v[39:8], v[7], v[6:0]);
    end

    // R8: completion on channel 6 clears only the go bit
    apply(1'b0, 8'h00, 32'h0, 7'h40);
    look("R8", 8'hE8, 32'h00000002, 1'b0, 7'h00);
    // R3: channel 1 not enabled, no launch
    apply(1'b1, 8'h98, 32'h01000000, 7'h00);
    look("R3", 8'h98, 32'h01000000, 1'b0, 7'h00);
    // R11: reset clears stored state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    look("R11", 8'hE4, 32'h0, 1'b0, 7'h00);
    look("R11", 8'hF4, 32'h0, 1'b0, 7'h00);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule